// File: doc/BRIEF.md
# At-Speed Datapath Test Wrapper

This block wraps a small datapath core so that a slow external tester can still exercise it at the full on-chip clock rate. The tester loads a set of operand vectors bit by bit into an on-chip input buffer. A strobe input paces that loading, so the slow tester rate is modelled on the fast clock. A single command then starts a burst. In the burst the core gets one buffered vector per fast clock cycle, back to back, and each result is captured into an on-chip output buffer. The tester then reads the results out serially, again at its own pace.

A two-bit mode select, qualified by a start pulse, picks the next phase: load, run or unload. Each phase returns to idle by itself once its work is done. A start pulse is honoured only while the wrapper is idle. The core inside is a stand-in ALU with four operations, so the wrapper's sequencing can be exercised end to end.

Top module: `atw_top`

## Requirements
- R1: After synchronous reset the wrapper is idle (`mode_o` = 0), `done` is low and `scan_out` is 0.
- R2: In idle, a `start` pulse with `mode_sel` 1 enters load, 2 enters run and 3 enters unload; `mode_o` then shows the same code. A `start` with `mode_sel` 0 leaves the wrapper idle.
- R3: A `start` pulse that arrives in load, run or unload is ignored. The phase in progress keeps its mode, its length and its data.
- R4: In load, one bit moves in on each clock where `shift_en` is high, and no bit moves on any other clock. After exactly N×(2W+2) strobes the wrapper returns to idle.
- R5: Each vector is 2W+2 bits laid out as {op[1:0], a[W-1:0], b[W-1:0]}. Vector 0 is shifted in first, and every vector is sent most significant bit first.
- R6: A run burst stays in run for exactly N consecutive clocks and applies vector k in its k-th clock.
- R7: The core computes, modulo 2^W: op 0 gives a+b, op 1 gives a−b, op 2 gives a AND b, op 3 gives a XOR b.
- R8: `done` is high for exactly one clock: the first idle clock after the burst.
- R9: The output buffer changes only during a run burst or an unload shift. Strobes in idle and a later load leave the captured results intact.
- R10: In unload, `scan_out` first shows result 0, most significant bit first, followed by the results in order. Each strobe moves to the next bit, and after N×W strobes the wrapper returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-speed clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Slow-rate shift strobe for load and unload |
| scan_in | input | 1 | Serial vector data in |
| mode_sel | input | 2 | Requested phase: 1 load, 2 run, 3 unload |
| start | input | 1 | Starts the selected phase when idle |
| scan_out | output | 1 | Serial result data out |
| mode_o | output | 2 | Current phase: 0 idle, 1 load, 2 run, 3 unload |
| done | output | 1 | One-clock pulse at the end of a run burst |

## Verification
The bench checks vectors whose add and subtract wrap around at 2^W. A core that lost the carry or the borrow would then return results that differ in their top bits. It sends start pulses in the middle of load, run and unload. A wrapper that accepted any of them would shorten the burst or mix up the serial streams, and the recovered results would not match. It also strobes while idle and reloads new vectors without a run, then reads the results out. A buffer that was not frozen outside run would show shifted or recomputed words. The serial order, vector 0 first and MSB first, is checked word by word, so a reversal of either the bit order or the vector order shows up at once.

// File: rtl/atw_pkg.sv
package atw_pkg;

    typedef enum logic [1:0] {
        M_IDLE   = 2'd0,
        M_LOAD   = 2'd1,
        M_RUN    = 2'd2,
        M_UNLOAD = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_XOR = 2'd3
    } op_e;

    localparam int unsigned OP_BITS = 2;

endpackage

// File: rtl/atw_ctrl.sv
module atw_ctrl
    import atw_pkg::*;
#(
    parameter int unsigned N  = 4,
    parameter int unsigned VW = 18,
    parameter int unsigned W  = 8,
    localparam int unsigned LBITS = N * VW,
    localparam int unsigned UBITS = N * W,
    localparam int unsigned CW = $clog2(LBITS),
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift_en,
    input  logic [1:0]    mode_sel,
    input  logic          start,
    output mode_e         mode_o,
    output logic          done_o,
    output logic          in_shift_o,
    output logic          out_shift_o,
    output logic          run_o,
    output logic [IW-1:0] run_idx_o
);

    mode_e         state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= M_IDLE;
            cnt    <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                M_IDLE: begin
                    if (start && mode_sel != 2'd0) begin
                        state <= mode_e'(mode_sel);
                        cnt   <= '0;
                    end
                end
                M_LOAD: begin
                    if (shift_en) begin
                        if (cnt == CW'(LBITS - 1)) state <= M_IDLE;
                        else cnt <= cnt + 1'b1;
                    end
                end
                M_RUN: begin
                    if (cnt == CW'(N - 1)) begin
                        state  <= M_IDLE;
                        done_o <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                M_UNLOAD: begin
                    if (shift_en) begin
                        if (cnt == CW'(UBITS - 1)) state <= M_IDLE;
                        else cnt <= cnt + 1'b1;
                    end
                end
                default: state <= M_IDLE;
            endcase
        end
    end

    assign mode_o      = state;
    assign in_shift_o  = (state == M_LOAD) && shift_en;
    assign out_shift_o = (state == M_UNLOAD) && shift_en;
    assign run_o       = (state == M_RUN);
    assign run_idx_o   = cnt[IW-1:0];

    // R6: the burst ends after its N-th clock and raises done
    a_r6_burst_end: assert property (@(posedge clk) disable iff (rst)
        (state == M_RUN && cnt == CW'(N - 1)) |=> (state == M_IDLE && done_o));

    // R8: done never lasts two clocks
    a_r8_done_once: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R3: a start during a burst does not cut it short
    a_r3_reject_run: assert property (@(posedge clk) disable iff (rst)
        (state == M_RUN && cnt != CW'(N - 1) && start) |=> (state == M_RUN));

    // R4: load waits for the strobe
    a_r4_load_waits: assert property (@(posedge clk) disable iff (rst)
        (state == M_LOAD && !shift_en) |=> (state == M_LOAD && $stable(cnt)));

endmodule

// File: rtl/atw_inbuf.sv
module atw_inbuf #(
    parameter int unsigned N  = 4,
    parameter int unsigned VW = 18,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift,
    input  logic          sin,
    input  logic [IW-1:0] rd_idx,
    output logic [VW-1:0] vec_o
);

    logic [N-1:0][VW-1:0] chain;

    for (genvar i = 0; i < N; i++) begin : g_slot
        logic feed;
        if (i == N - 1) begin : g_tail
            assign feed = sin;
        end else begin : g_mid
            assign feed = chain[i+1][VW-1];
        end
        always_ff @(posedge clk) begin
            if (rst)        chain[i] <= '0;
            else if (shift) chain[i] <= {chain[i][VW-2:0], feed};
        end
    end

    assign vec_o = chain[rd_idx];

    // R4: loaded vectors hold between strobes
    a_r4_chain_hold: assert property (@(posedge clk) disable iff (rst)
        !shift |=> $stable(chain));

endmodule

// File: rtl/atw_core.sv
module atw_core
    import atw_pkg::*;
#(
    parameter int unsigned W = 8,
    localparam int unsigned VW = 2 * W + OP_BITS
) (
    input  logic [VW-1:0] vec_i,
    output logic [W-1:0]  res_o
);

    op_e          op;
    logic [W-1:0] a;
    logic [W-1:0] b;

    assign op = op_e'(vec_i[VW-1 -: OP_BITS]);
    assign a  = vec_i[2*W-1 -: W];
    assign b  = vec_i[W-1:0];

    always_comb begin
        case (op)
            OP_ADD:  res_o = a + b;
            OP_SUB:  res_o = a - b;
            OP_AND:  res_o = a & b;
            default: res_o = a ^ b;
        endcase
    end

endmodule

// File: rtl/atw_outbuf.sv
module atw_outbuf #(
    parameter int unsigned N = 4,
    parameter int unsigned W = 8,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic          shift,
    output logic          sout
);

    logic [N-1:0][W-1:0] res;

    for (genvar i = 0; i < N; i++) begin : g_slot
        logic feed;
        if (i == N - 1) begin : g_tail
            assign feed = 1'b0;
        end else begin : g_mid
            assign feed = res[i+1][W-1];
        end
        always_ff @(posedge clk) begin
            if (rst)
                res[i] <= '0;
            else if (wr_en && wr_idx == IW'(i))
                res[i] <= wr_data;
            else if (shift)
                res[i] <= {res[i][W-2:0], feed};
        end
    end

    assign sout = res[0][W-1];

    // R9: results frozen outside the burst and unload shifts
    a_r9_obuf_hold: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !shift) |=> $stable(res));

endmodule

// File: rtl/atw_top.sv
module atw_top
    import atw_pkg::*;
#(
    parameter int unsigned N = 4,
    parameter int unsigned W = 8,
    localparam int unsigned VW = 2 * W + OP_BITS,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       shift_en,
    input  logic       scan_in,
    input  logic [1:0] mode_sel,
    input  logic       start,
    output logic       scan_out,
    output logic [1:0] mode_o,
    output logic       done
);

    mode_e         mode;
    logic          in_shift;
    logic          out_shift;
    logic          run;
    logic [IW-1:0] run_idx;
    logic [VW-1:0] vec;
    logic [W-1:0]  res;

    atw_ctrl #(.N(N), .VW(VW), .W(W)) u_ctrl (
        .clk(clk), .rst(rst), .shift_en(shift_en), .mode_sel(mode_sel),
        .start(start), .mode_o(mode), .done_o(done), .in_shift_o(in_shift),
        .out_shift_o(out_shift), .run_o(run), .run_idx_o(run_idx)
    );

    atw_inbuf #(.N(N), .VW(VW)) u_in (
        .clk(clk), .rst(rst), .shift(in_shift), .sin(scan_in),
        .rd_idx(run_idx), .vec_o(vec)
    );

    atw_core #(.W(W)) u_core (
        .vec_i(vec), .res_o(res)
    );

    atw_outbuf #(.N(N), .W(W)) u_out (
        .clk(clk), .rst(rst), .wr_en(run), .wr_idx(run_idx), .wr_data(res),
        .shift(out_shift), .sout(scan_out)
    );

    assign mode_o = mode;

endmodule

// File: tb/sim_atw_top.sv
module sim_atw_top;

    localparam int N  = 4;
    localparam int W  = 8;
    localparam int VW = 2 * W + 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       shift_en = 1'b0;
    logic       scan_in = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic       start = 1'b0;
    logic       scan_out;
    logic [1:0] mode_o;
    logic       done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [VW-1:0] vecs [N];
    logic [W-1:0]  expv [N];

    atw_top #(.N(N), .W(W)) u0 (
        .clk(clk), .rst(rst), .shift_en(shift_en), .scan_in(scan_in),
        .mode_sel(mode_sel), .start(start), .scan_out(scan_out),
        .mode_o(mode_o), .done(done)
    );

    always #5 clk = ~clk;

    function automatic logic [W-1:0] alu_ref(logic [VW-1:0] v);
        logic [W-1:0] a = v[2*W-1 -: W];
        logic [W-1:0] b = v[W-1:0];
        case (v[VW-1 -: 2])
            2'd0:    return a + b;
            2'd1:    return a - b;
            2'd2:    return a & b;
            default: return a ^ b;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(logic [1:0] m);
        @(negedge clk); start = 1'b1; mode_sel = m;
        @(negedge clk); start = 1'b0; mode_sel = 2'd0;
    endtask

    task automatic strobe();
        @(negedge clk); shift_en = 1'b1;
        @(negedge clk); shift_en = 1'b0;
        repeat ($urandom_range(2)) @(negedge clk);
    endtask

    task automatic load_vecs(bit inject);
        int n = 0;
        pulse_start(2'd1);
        chk("R2 load entered", mode_o, 2'd1);
        for (int v = 0; v < N; v++) begin
            for (int b = VW - 1; b >= 0; b--) begin
                @(negedge clk); scan_in = vecs[v][b];
                strobe();
                n++;
                if (inject && n == 5) begin
                    pulse_start(2'd2);
                    chk("R3 start ignored in load", mode_o, 2'd1);
                end
                if (n == N * VW - 1) chk("R4 load still open", mode_o, 2'd1);
            end
        end
        chk("R4 load ends after all strobes", mode_o, 2'd0);
    endtask

    task automatic run_burst(bit inject);
        @(negedge clk); start = 1'b1; mode_sel = 2'd2;
        @(negedge clk); start = 1'b0; mode_sel = 2'd0;
        for (int k = 0; k < N; k++) begin
            chk("R6 in run", mode_o, 2'd2);
            chk("R8 no done in run", done, 1'b0);
            if (inject && k == 1) begin start = 1'b1; mode_sel = 2'd3; end
            @(negedge clk);
            start = 1'b0; mode_sel = 2'd0;
        end
        chk("R6 idle after N clocks", mode_o, 2'd0);
        chk("R8 done pulse", done, 1'b1);
        @(negedge clk);
        chk("R8 done single clock", done, 1'b0);
    endtask

    task automatic unload_check(bit inject);
        pulse_start(2'd3);
        chk("R2 unload entered", mode_o, 2'd3);
        for (int v = 0; v < N; v++) begin
            logic [W-1:0] got;
            for (int b = W - 1; b >= 0; b--) begin
                got[b] = scan_out;
                strobe();
            end
            chk("R10 R7 R5 result order and value", got, expv[v]);
            if (inject && v == 0) begin
                pulse_start(2'd1);
                chk("R3 start ignored in unload", mode_o, 2'd3);
            end
        end
        chk("R10 idle after unload", mode_o, 2'd0);
    endtask

    task automatic set_expect();
        for (int v = 0; v < N; v++) expv[v] = alu_ref(vecs[v]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset mode", mode_o, 2'd0);
        chk("R1 reset done", done, 1'b0);
        chk("R1 reset scan_out", scan_out, 1'b0);

        pulse_start(2'd0);
        chk("R2 mode 0 stays idle", mode_o, 2'd0);

        // directed wrap cases for R7
        vecs[0] = {2'd0, 8'hFF, 8'h01};
        vecs[1] = {2'd1, 8'h00, 8'h01};
        vecs[2] = {2'd2, 8'hA5, 8'h3C};
        vecs[3] = {2'd3, 8'hA5, 8'h3C};
        set_expect();
        load_vecs(1'b1);
        run_burst(1'b1);
        unload_check(1'b1);

        for (int r = 0; r < 4; r++) begin
            for (int v = 0; v < N; v++) vecs[v] = VW'($urandom);
            set_expect();
            load_vecs(1'b0);
            run_burst(1'b0);
            // R9: idle strobes and a fresh load must not disturb results
            repeat (3) strobe();
            for (int v = 0; v < N; v++) vecs[v] = VW'($urandom);
            load_vecs(1'b0);
            unload_check(1'b0);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule